// File: doc/BRIEF.md
# Banked Interrupt Enable Controller

This block collects 96 level-sensitive interrupt sources into three banks of 32 and gives software a small register window over them. Each bank keeps its own enable mask, and that mask is changed only through a pair of write-only ports. Ones written to the set port turn bits on. Ones written to the clear port turn bits off. Software therefore never has to read, modify and write a mask, and two agents can enable or disable different sources without racing.

Software sees, per bank, the sources that are both asserted and enabled. One combined interrupt line tells the processor that at least one enabled source is active. A 32-bit storage word sits in the window for fast-interrupt configuration. This block only holds that word and does not act on it.

The source vector uses a global numbering. Bank 1 carries sources 0 to 31, bank 2 carries sources 32 to 63, and bank 0 carries sources 64 to 95. Access is through a simple synchronous bus with a byte address, a write strobe with data, and a read strobe whose data is returned one cycle later.

Top module: `bic_top`

## Requirements
- R1: After reset, every enable bit is 0, the storage word at byte offset 0x0C reads 0, `irq_o` is 0 and `bus_rdata_o` is 0.
- R2: A read of byte offset 0x00, 0x04 or 0x08 returns the pending word of bank 0, bank 1 or bank 2 respectively, which is the source levels ANDed with that bank's enable bits. Bank 0 is `src_i[95:64]`, bank 1 is `src_i[31:0]` and bank 2 is `src_i[63:32]`.
- R3: A write to byte offset 0x10 (bank 1), 0x14 (bank 2) or 0x18 (bank 0) sets every enable bit of that bank whose data bit is 1, effective from the next cycle. Enable bits whose data bit is 0 keep their value.
- R4: A write to byte offset 0x1C (bank 1), 0x20 (bank 2) or 0x24 (bank 0) clears every enable bit of that bank whose data bit is 1. Bits whose data bit is 0 keep their value, so writing 0xFFFFFFFF masks the whole bank.
- R5: Byte offset 0x0C is a 32-bit read/write storage word. Writing it changes no enable bit and does not affect `irq_o`.
- R6: `irq_o` equals the OR of all enabled pending bits of the three banks as they stood at the previous clock edge, which is one cycle of latency.
- R7: Reads have no side effects. Writes to the pending offsets or to any unmapped offset change nothing. Reads of the set or clear offsets, or of unmapped offsets, return 0.
- R8: Read data appears on `bus_rdata_o` in the cycle after the read strobe and holds until the next read strobe. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Level-sensitive sources in global numbering |
| bus_addr_i | input | 6 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request, registered |

## Verification
The only hidden state is the three enable masks and the storage word. A wrong enable bit shows up in two places: in the pending word of its bank at the next read, and on `irq_o` one cycle after its source is driven high while every other source is low. The bench therefore drives sources with isolated bit patterns and reads each bank after every mask change. A decode fault that routes a set or clear to the wrong bank shows at the pending offset of the bank that was not written, in the first read after the write.

// File: rtl/bic_pkg.sv
package bic_pkg;
    localparam int NUM_BANKS    = 3;
    localparam int BANK_W       = 32;
    localparam int SRC_W        = NUM_BANKS * BANK_W;
    localparam int FIQ_IDX      = NUM_BANKS;
    localparam int SET_IDX0     = NUM_BANKS + 1;
    localparam int CLR_IDX0     = 2 * NUM_BANKS + 1;
    localparam int WORD_IDX_MAX = 3 * NUM_BANKS;
    localparam int WIDX_W       = $clog2(WORD_IDX_MAX + 1);
    localparam int ADDR_W       = WIDX_W + 2;

    typedef logic [BANK_W-1:0] word_t;

    // Slot of a bank in the global source numbering and in the set/clear
    // register rows: bank 1 first, then bank 2, bank 0 last.
    function automatic int bank_slot(input int b);
        return (b + NUM_BANKS - 1) % NUM_BANKS;
    endfunction

    typedef struct packed {
        word_t en;
    } bank_state_t;

    typedef struct packed {
        logic irq;
    } irq_state_t;

    typedef struct packed {
        word_t fiq;
        word_t rdata;
    } top_state_t;
endpackage

// File: rtl/bic_decode.sv
module bic_decode
    import bic_pkg::*;
(
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        wr_i,
    input  word_t                       wdata_i,
    output logic [NUM_BANKS-1:0][BANK_W-1:0] set_mask_o,
    output logic [NUM_BANKS-1:0][BANK_W-1:0] clr_mask_o,
    output logic                        fiq_we_o,
    output logic [NUM_BANKS-1:0]        rd_pend_sel_o,
    output logic                        rd_fiq_sel_o
);
    logic [WIDX_W-1:0] widx;
    logic [1:0]        unused_addr_lsb;

    assign widx            = addr_i[ADDR_W-1:2];
    assign unused_addr_lsb = addr_i[1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_dec
        localparam int SLOT = bank_slot(b);
        localparam logic [WIDX_W-1:0] SET_W = WIDX_W'(SET_IDX0 + SLOT);
        localparam logic [WIDX_W-1:0] CLR_W = WIDX_W'(CLR_IDX0 + SLOT);
        localparam logic [WIDX_W-1:0] PND_W = WIDX_W'(b);

        assign set_mask_o[b]    = (wr_i && widx == SET_W) ? wdata_i : '0;
        assign clr_mask_o[b]    = (wr_i && widx == CLR_W) ? wdata_i : '0;
        assign rd_pend_sel_o[b] = (widx == PND_W);
    end

    assign fiq_we_o     = wr_i && (widx == WIDX_W'(FIQ_IDX));
    assign rd_fiq_sel_o = (widx == WIDX_W'(FIQ_IDX));
endmodule

// File: rtl/bic_bank.sv
module bic_bank
    import bic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t src_i,
    input  word_t set_mask_i,
    input  word_t clr_mask_i,
    output word_t pend_o
);
    bank_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = (st_q.en | set_mask_i) & ~clr_mask_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = src_i & st_q.en;

    // R3: ones written to the set port are enabled one cycle later
    p_set_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask_i != '0) |=> ((st_q.en & $past(set_mask_i)) == $past(set_mask_i)));

    // R4: ones written to the clear port are disabled one cycle later
    p_clr_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask_i != '0) |=> ((st_q.en & $past(clr_mask_i)) == '0));

    // R3 R4: bits not written as one keep their value
    p_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.en & ~$past(set_mask_i | clr_mask_i)) ==
         ($past(st_q.en) & ~$past(set_mask_i | clr_mask_i))));
endmodule

// File: rtl/bic_irq_gen.sv
module bic_irq_gen
    import bic_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] pend_i,
    output logic                             irq_o
);
    irq_state_t st_d, st_q;
    logic       any_pend;

    always_comb begin
        any_pend = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            any_pend = any_pend | (|pend_i[b]);
        end
        st_d     = st_q;
        st_d.irq = any_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    // R6: request follows the enabled pending state with one cycle latency
    p_irq_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(any_pend));
endmodule

// File: rtl/bic_top.sv
module bic_top
    import bic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [BANK_W-1:0] bus_wdata_i,
    input  logic              bus_rd_i,
    output logic [BANK_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    logic [NUM_BANKS-1:0][BANK_W-1:0] set_mask;
    logic [NUM_BANKS-1:0][BANK_W-1:0] clr_mask;
    logic [NUM_BANKS-1:0][BANK_W-1:0] pend;
    logic [NUM_BANKS-1:0]             rd_pend_sel;
    logic                             rd_fiq_sel;
    logic                             fiq_we;
    word_t                            rd_word;
    top_state_t                       st_d, st_q;

    bic_decode i_decode (
        .addr_i        (bus_addr_i),
        .wr_i          (bus_wr_i),
        .wdata_i       (bus_wdata_i),
        .set_mask_o    (set_mask),
        .clr_mask_o    (clr_mask),
        .fiq_we_o      (fiq_we),
        .rd_pend_sel_o (rd_pend_sel),
        .rd_fiq_sel_o  (rd_fiq_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int BASE = bank_slot(b) * BANK_W;
        bic_bank i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_i[BASE +: BANK_W]),
            .set_mask_i (set_mask[b]),
            .clr_mask_i (clr_mask[b]),
            .pend_o     (pend[b])
        );
    end

    bic_irq_gen i_irq_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .irq_o  (irq_o)
    );

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_pend_sel[b]) rd_word = pend[b];
        end
        if (rd_fiq_sel) rd_word = st_q.fiq;

        st_d = st_q;
        if (fiq_we)   st_d.fiq   = bus_wdata_i;
        if (bus_rd_i) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata_o = st_q.rdata;

    // R8: read data holds while no read strobe is given
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> $stable(bus_rdata_o));

    // R5: storage word changes only on a write to its own offset
    p_fiq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && bus_addr_i[ADDR_W-1:2] == WIDX_W'(FIQ_IDX)) |=> $stable(st_q.fiq));

    // R5: a write to the storage word is returned by the next read of it
    p_fiq_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i[ADDR_W-1:2] == WIDX_W'(FIQ_IDX)) |=> (st_q.fiq == $past(bus_wdata_i)));
endmodule

// File: tb/test_bic_top.sv
module test_bic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic [5:0]  addr = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_en [3];
    logic [31:0] m_fiq;

    always #4 clk = ~clk;

    bic_top i_bic_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_wr_i    (wr),
        .bus_wdata_i (wdata),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [31:0] src_of(int b);
        case (b)
            0:       return src[95:64];
            1:       return src[31:0];
            default: return src[63:32];
        endcase
    endfunction

    function automatic logic [5:0] set_addr(int b);
        case (b)
            0:       return 6'h18;
            1:       return 6'h10;
            default: return 6'h14;
        endcase
    endfunction

    function automatic logic [5:0] clr_addr(int b);
        return set_addr(b) + 6'h0C;
    endfunction

    function automatic logic [31:0] exp_pend(int b);
        return src_of(b) & m_en[b];
    endfunction

    function automatic logic [31:0] exp_irq();
        return {31'd0, |(exp_pend(0) | exp_pend(1) | exp_pend(2))};
    endfunction

    function automatic logic [31:0] exp_read(logic [5:0] a);
        logic [5:0] w = {a[5:2], 2'b00};
        if (w == 6'h00) return exp_pend(0);
        if (w == 6'h04) return exp_pend(1);
        if (w == 6'h08) return exp_pend(2);
        if (w == 6'h0C) return m_fiq;
        return '0;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_write(logic [5:0] a, logic [31:0] d);
        logic [5:0] w = {a[5:2], 2'b00};
        for (int b = 0; b < 3; b++) begin
            if (w == set_addr(b)) m_en[b] = m_en[b] | d;
            if (w == clr_addr(b)) m_en[b] = m_en[b] & ~d;
        end
        if (w == 6'h0C) m_fiq = d;
    endtask

    // All tasks start and end just after a falling edge.
    task automatic bus_write(logic [5:0] a, logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read(logic [5:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic read_check(string req, logic [5:0] a);
        logic [31:0] e;
        logic [31:0] d;
        e = exp_read(a);
        bus_read(a, d);
        check(req, $sformatf("read @%h", a), d, e);
    endtask

    task automatic irq_check(string req);
        @(negedge clk);
        check(req, "irq", {31'd0, irq}, exp_irq());
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] hold;
        void'($urandom(32'd13579));
        for (int b = 0; b < 3; b++) m_en[b] = '0;
        m_fiq = '0;
        src = '1;
        repeat (3) @(negedge clk);
        check("R1", "rdata in reset", rdata, 32'h0);
        check("R1", "irq in reset", {31'd0, irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "irq after reset, all sources high", {31'd0, irq}, 32'h0);
        read_check("R1", 6'h00);
        read_check("R1", 6'h04);
        read_check("R1", 6'h08);
        read_check("R1", 6'h0C);

        // R3 and R2: distinct masks per bank, bank mapping checked through pending
        bus_write(set_addr(0), 32'hA5A5_0001);
        bus_write(set_addr(1), 32'h0000_00F0);
        bus_write(set_addr(2), 32'h8000_0000);
        read_check("R2", 6'h00);
        read_check("R2", 6'h04);
        read_check("R2", 6'h08);
        src = {32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_0030};
        read_check("R2", 6'h00);
        read_check("R2", 6'h04);
        read_check("R2", 6'h08);
        src = '1;
        // R3: zeros leave enable bits alone
        bus_write(set_addr(1), 32'h0000_0F00);
        read_check("R3", 6'h04);
        bus_write(set_addr(0), 32'h0);
        read_check("R3", 6'h00);

        // R4: partial clear, then full mask
        bus_write(clr_addr(0), 32'h0000_0001);
        read_check("R4", 6'h00);
        bus_write(clr_addr(1), 32'h0000_00F0);
        read_check("R4", 6'h04);
        read_check("R4", 6'h08);
        bus_write(clr_addr(2), 32'hFFFF_FFFF);
        read_check("R4", 6'h08);
        read_check("R4", 6'h00);

        // R5: storage word
        bus_write(6'h0C, 32'hDEAD_BEEF);
        read_check("R5", 6'h0C);
        read_check("R5", 6'h00);
        read_check("R5", 6'h04);
        read_check("R5", 6'h08);

        // R6: latency of one cycle
        for (int b = 0; b < 3; b++) bus_write(clr_addr(b), 32'hFFFF_FFFF);
        src = '0;
        bus_write(set_addr(2), 32'h0000_0100);
        bus_write(6'h0C, 32'h0000_0000);
        irq_check("R6");
        src[40] = 1'b1;
        #1;
        check("R6", "irq before edge", {31'd0, irq}, 32'h0);
        @(negedge clk);
        check("R6", "irq one cycle after source", {31'd0, irq}, 32'h1);
        src[41] = 1'b1;
        src[40] = 1'b0;
        @(negedge clk);
        check("R6", "irq drops for disabled source", {31'd0, irq}, 32'h0);
        src[40] = 1'b1;
        irq_check("R6");
        bus_write(clr_addr(2), 32'h0000_0100);
        check("R6", "irq still set right after clear write", {31'd0, irq}, 32'h1);
        irq_check("R6");

        // R7: ignored writes and side-effect-free reads
        src = '1;
        bus_write(set_addr(1), 32'h1234_5678);
        bus_write(6'h04, 32'hFFFF_FFFF);
        bus_write(6'h00, 32'hFFFF_FFFF);
        bus_write(6'h28, 32'hFFFF_FFFF);
        bus_write(6'h3C, 32'hFFFF_FFFF);
        read_check("R7", 6'h04);
        read_check("R7", 6'h04);
        read_check("R7", 6'h00);
        read_check("R7", 6'h10);
        read_check("R7", 6'h24);
        read_check("R7", 6'h2C);
        read_check("R5", 6'h0C);

        // R8: data holds without strobe; low address bits ignored
        bus_read(6'h07, d);
        check("R8", "read with low bits set", d, exp_pend(1));
        hold = d;
        src = '0;
        repeat (3) @(negedge clk);
        check("R8", "rdata hold", rdata, hold);

        // Random mix
        for (int i = 0; i < 500; i++) begin
            int op;
            int b;
            op = $urandom % 6;
            b = $urandom % 3;
            case (op)
                0: bus_write(set_addr(b), $urandom);
                1: bus_write(clr_addr(b), $urandom);
                2: bus_write(6'h0C, $urandom);
                3: read_check("R2", 6'(($urandom % 16) * 4));
                4: src = {$urandom, $urandom, $urandom};
                default: src = 96'd1 << ($urandom % 96);
            endcase
            irq_check("R6");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule